// File: doc/BRIEF.md
# Converter Block and De-block Sequencer

This block sequences the protective blocking and the later release of one full-bridge converter station in a DC grid. It watches three fault indications: a pole overcurrent on the positive pole, a pole overcurrent on the negative pole, and a fault flag from the nearby DC relay. After a programmable delay it raises a block order that stops the converter's firing pulses. Local overcurrent uses a short delay. A relay-reported fault uses a longer one, which allows for busbar processing time. All delays are counted on a sample tick, not on the clock.

While blocked, the block decides when the converter may resume. In rectifier mode there are three ways to release it:

- Every disconnector that was classified as internal to the faulty link reports open. Release then follows a settling delay.
- The local DC voltage recovers.
- No local disconnector was classified as internal, and the converter has stayed blocked for a maximum time.

In inverter mode only voltage recovery releases it. Measurement, the threshold comparators and the converter control are outside the block and arrive as single-bit flags.

Top module: `conv_block_seq`

## Requirements
- R1: After reset the sequencer is idle: `state_o` = 0 (idle), `block_o` = 0 and `deblock_o` = 0. With no trigger present, the idle state holds.
- R2: When `oc_pos` or `oc_neg` is sampled high in idle (or run), `state_o` becomes 1 (block pending) at the next edge. `block_o` then rises with `state_o` = 2 (blocked) at the LOC_DLY-th tick edge after that edge. Edges without a tick never advance the count.
- R3: When `relay_flt` alone is sampled high in idle, `state_o` becomes 1. The blocked state follows at the REL_DLY-th tick edge after that.
- R4: If local and relay triggers are sampled together, the shorter of LOC_DLY and REL_DLY applies. Any trigger that arrives while the state is 1, 2 or 3 is ignored: the pending delay does not change, and the blocked state never returns to 0 or 1.
- R5: `block_o` is 1 exactly in states 2 and 3. `deblock_o` is 1 exactly in state 4 (run). The two outputs are never high together.
- R6: In rectifier mode (`inv_mode` = 0) in state 2, the state moves to 3 (de-block pending) at the next edge once at least one `disc_int` bit is set and every disc_int-flagged bit of `disc_open` is set. State 4 follows at the DEB_DLY-th tick edge after that.
- R7: In rectifier mode, `volt_ok` sampled high in state 2 or 3 moves the state to 4 at the next edge.
- R8: In rectifier mode with no `disc_int` bit set, state 2 moves to 4 at the MAX_DLY-th tick edge after entering it. While any `disc_int` bit is set, the time limit never releases it.
- R9: In inverter mode (`inv_mode` = 1), state 2 is left only through `volt_ok`, which goes to 4 at the next edge. Disconnector status and the time limit have no effect.
- R10: In state 4, a trigger starts a new block sequence exactly as it does in idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Sample tick; qualifies every delay count |
| oc_pos | input | 1 | Positive pole local overcurrent flag |
| oc_neg | input | 1 | Negative pole local overcurrent flag |
| relay_flt | input | 1 | Fault detected by the nearby DC relay |
| disc_int | input | N_DISC | Disconnector classified internal to the faulty link |
| disc_open | input | N_DISC | Disconnector reports open |
| volt_ok | input | 1 | Local DC voltage recovered to near nominal |
| inv_mode | input | 1 | 1 = inverter, 0 = rectifier |
| block_o | output | 1 | Block order: stop firing pulses |
| deblock_o | output | 1 | De-block: converter control resumed |
| state_o | output | 3 | Sequencer state (0 idle, 1 block pending, 2 blocked, 3 de-block pending, 4 run) |

## Verification
The in-line assertions check the transitions that can be stated cycle by cycle:

- a trigger in idle or run always arms a pending block;
- a pending block never moves on an edge without a tick;
- the blocked state never falls back to idle or pending;
- in rectifier mode, voltage recovery and completed isolation take effect at once;
- an inverter without voltage recovery stays blocked;
- the shared delay counter never reaches its target.

Only the bench scenarios can show the exact length of each delay in ticks. They also show which delay wins when both triggers arrive together, that late triggers leave the delay unchanged, and the partial-isolation cases. In those cases the maximum-time fallback must stay inactive while internal disconnectors exist.

// File: rtl/cbd_pkg.sv
package cbd_pkg;
  typedef enum logic [2:0] {
    ST_NORMAL    = 3'd0,
    ST_BLK_PEND  = 3'd1,
    ST_BLOCKED   = 3'd2,
    ST_DBLK_PEND = 3'd3,
    ST_RUN       = 3'd4
  } cbd_state_e;
endpackage

// File: rtl/cbd_trig_sel.sv
// Merges the block triggers and picks the delay of the path that fires first.
module cbd_trig_sel #(
  parameter int LOC_DLY = 1,
  parameter int REL_DLY = 20,
  parameter int CW      = 5
) (
  input  logic          oc_pos,
  input  logic          oc_neg,
  input  logic          relay_flt,
  output logic          fire_o,
  output logic [CW-1:0] dly_o
);
  localparam int              FAST   = (LOC_DLY < REL_DLY) ? LOC_DLY : REL_DLY;
  localparam logic [CW-1:0]   LOC_W  = CW'(LOC_DLY);
  localparam logic [CW-1:0]   REL_W  = CW'(REL_DLY);
  localparam logic [CW-1:0]   FAST_W = CW'(FAST);

  logic local_oc;

  always_comb begin
    local_oc = oc_pos | oc_neg;
    fire_o   = local_oc | relay_flt;
    if (local_oc && relay_flt) dly_o = FAST_W;
    else if (local_oc)         dly_o = LOC_W;
    else                       dly_o = REL_W;
  end
endmodule

// File: rtl/cbd_timer.sv
// Tick counter shared by every timed state; expires on the target-th tick.
module cbd_timer #(
  parameter int CW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr_i,
  input  logic          tick_i,
  input  logic [CW-1:0] target_i,
  output logic          expire_o
);
  localparam logic [CW-1:0] ONE = CW'(1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          at_end, cnt_en;

  always_comb begin
    at_end   = (cnt_q == target_i - ONE);
    expire_o = tick_i & at_end;
    cnt_en   = clr_i | tick_i;
    cnt_d    = cnt_q;
    if (clr_i)        cnt_d = '0;
    else if (!at_end) cnt_d = cnt_q + ONE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  AST_CNT_BELOW_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_i |-> (cnt_q < target_i)) else $error("counter passed its target"); // R8
endmodule

// File: rtl/cbd_restore.sv
// Isolation status over the disconnector set.
module cbd_restore #(
  parameter int N_DISC = 2
) (
  input  logic [N_DISC-1:0] disc_int,
  input  logic [N_DISC-1:0] disc_open,
  output logic              any_int_o,
  output logic              iso_done_o
);
  logic [N_DISC-1:0] still_closed;

  for (genvar g = 0; g < N_DISC; g++) begin : g_disc
    assign still_closed[g] = disc_int[g] & ~disc_open[g];
  end

  assign any_int_o  = |disc_int;
  assign iso_done_o = any_int_o & ~(|still_closed);
endmodule

// File: rtl/conv_block_seq.sv
module conv_block_seq
  import cbd_pkg::*;
#(
  parameter int N_DISC  = 2,
  parameter int LOC_DLY = 1,
  parameter int REL_DLY = 20,
  parameter int DEB_DLY = 50,
  parameter int MAX_DLY = 2000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              oc_pos,
  input  logic              oc_neg,
  input  logic              relay_flt,
  input  logic [N_DISC-1:0] disc_int,
  input  logic [N_DISC-1:0] disc_open,
  input  logic              volt_ok,
  input  logic              inv_mode,
  output logic              block_o,
  output logic              deblock_o,
  output logic [2:0]        state_o
);
  localparam int M1 = (LOC_DLY > REL_DLY) ? LOC_DLY : REL_DLY;
  localparam int M2 = (DEB_DLY > MAX_DLY) ? DEB_DLY : MAX_DLY;
  localparam int TOP = (M1 > M2) ? M1 : M2;
  localparam int CW  = $clog2(TOP + 1);
  localparam logic [CW-1:0] DEB_W = CW'(DEB_DLY);
  localparam logic [CW-1:0] MAX_W = CW'(MAX_DLY);

  cbd_state_e    state_q, state_d;
  logic [CW-1:0] pend_dly_q, sel_dly, tgt;
  logic          fire, expire, clr, timed, tmr_tick, load_dly;
  logic          any_int, iso_done;

  cbd_trig_sel #(.LOC_DLY(LOC_DLY), .REL_DLY(REL_DLY), .CW(CW)) u_trig (
    .oc_pos(oc_pos), .oc_neg(oc_neg), .relay_flt(relay_flt),
    .fire_o(fire), .dly_o(sel_dly)
  );

  cbd_restore #(.N_DISC(N_DISC)) u_rest (
    .disc_int(disc_int), .disc_open(disc_open),
    .any_int_o(any_int), .iso_done_o(iso_done)
  );

  cbd_timer #(.CW(CW)) u_tmr (
    .clk(clk), .rst_n(rst_n), .clr_i(clr), .tick_i(tmr_tick),
    .target_i(tgt), .expire_o(expire)
  );

  // Timer target and enable by state
  always_comb begin
    timed = 1'b1;
    unique case (state_q)
      ST_BLK_PEND:  tgt = pend_dly_q;
      ST_BLOCKED:   tgt = MAX_W;
      ST_DBLK_PEND: tgt = DEB_W;
      default: begin
        tgt   = MAX_W;
        timed = 1'b0;
      end
    endcase
    tmr_tick = tick & timed;
  end

  // Next-state
  always_comb begin
    state_d  = state_q;
    load_dly = 1'b0;
    unique case (state_q)
      ST_NORMAL, ST_RUN: begin
        if (fire) begin
          state_d  = ST_BLK_PEND;
          load_dly = 1'b1;
        end
      end
      ST_BLK_PEND: begin
        if (expire) state_d = ST_BLOCKED;
      end
      ST_BLOCKED: begin
        if (volt_ok)                          state_d = ST_RUN;
        else if (!inv_mode && iso_done)       state_d = ST_DBLK_PEND;
        else if (!inv_mode && expire && !any_int) state_d = ST_RUN;
      end
      ST_DBLK_PEND: begin
        if (volt_ok || expire) state_d = ST_RUN;
      end
      default: state_d = ST_NORMAL;
    endcase
    clr = (state_d != state_q);
  end

  // Registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_NORMAL;
    else        state_q <= state_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        pend_dly_q <= '0;
    else if (load_dly) pend_dly_q <= sel_dly;
  end

  assign block_o   = (state_q == ST_BLOCKED) || (state_q == ST_DBLK_PEND);
  assign deblock_o = (state_q == ST_RUN);
  assign state_o   = state_q;

  // Assertions
  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_NORMAL && !(oc_pos || oc_neg || relay_flt)) |=> (state_q == ST_NORMAL))
    else $error("idle left without trigger"); // R1
  AST_TRIG_ARMS: assert property (@(posedge clk) disable iff (!rst_n)
    ((state_q == ST_NORMAL || state_q == ST_RUN) && (oc_pos || oc_neg || relay_flt))
    |=> (state_q == ST_BLK_PEND)) else $error("trigger did not arm"); // R10
  AST_PEND_NEEDS_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_BLK_PEND && !tick) |=> (state_q == ST_BLK_PEND))
    else $error("pending advanced without tick"); // R2
  AST_BLOCK_NO_REARM: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_BLOCKED) |=> (state_q != ST_NORMAL && state_q != ST_BLK_PEND))
    else $error("blocked state re-armed"); // R4
  AST_RECT_VOLT_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    ((state_q == ST_BLOCKED || state_q == ST_DBLK_PEND) && !inv_mode && volt_ok)
    |=> (state_q == ST_RUN)) else $error("voltage recovery ignored"); // R7
  AST_ISO_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_BLOCKED && !inv_mode && !volt_ok && iso_done)
    |=> (state_q == ST_DBLK_PEND)) else $error("isolation not acted on"); // R6
  AST_INV_NEEDS_VOLT: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_BLOCKED && inv_mode && !volt_ok) |=> (state_q == ST_BLOCKED))
    else $error("inverter released without voltage"); // R9
endmodule

// File: tb/tb_conv_block_seq.sv
`timescale 1ns/1ps
module tb_conv_block_seq;
  localparam int ND   = 2;
  localparam int LOC  = 2;
  localparam int REL  = 5;
  localparam int DEB  = 4;
  localparam int MAXT = 12;
  localparam int TDIV = 3;

  logic clk = 1'b0;
  logic rst_n, tick, oc_pos, oc_neg, relay_flt, volt_ok, inv_mode;
  logic [ND-1:0] disc_int, disc_open;
  logic block_o, deblock_o;
  logic [2:0] state_o;
  int vectors = 0;
  int fails = 0;
  int div = 0;

  always #4 clk = ~clk;

  always @(negedge clk) begin
    div  = (div == TDIV - 1) ? 0 : div + 1;
    tick = (div == TDIV - 1);
  end

  conv_block_seq #(.N_DISC(ND), .LOC_DLY(LOC), .REL_DLY(REL), .DEB_DLY(DEB),
                   .MAX_DLY(MAXT)) dut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .oc_pos(oc_pos), .oc_neg(oc_neg),
    .relay_flt(relay_flt), .disc_int(disc_int), .disc_open(disc_open),
    .volt_ok(volt_ok), .inv_mode(inv_mode), .block_o(block_o),
    .deblock_o(deblock_o), .state_o(state_o)
  );

  task automatic check(input string req, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  // state plus output decode (R5)
  task automatic check_st(input string req, input int exp);
    check(req, int'(state_o), exp);
    check("R5 block_o", int'(block_o), (exp == 2 || exp == 3) ? 1 : 0);
    check("R5 deblock_o", int'(deblock_o), (exp == 4) ? 1 : 0);
  endtask

  task automatic tick_edges(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      while (!tick) @(posedge clk);
    end
    #1;
  endtask

  task automatic do_reset();
    @(negedge clk);
    oc_pos = 0; oc_neg = 0; relay_flt = 0; volt_ok = 0; inv_mode = 0;
    disc_int = '0; disc_open = '0;
    rst_n = 0;
    repeat (2) @(posedge clk);
    @(negedge clk) rst_n = 1;
  endtask

  // kind: 0 pos, 1 neg, 2 relay, 3 both together
  task automatic arm(input int kind);
    int exp_d;
    @(negedge clk);
    oc_pos    = (kind == 0 || kind == 3);
    oc_neg    = (kind == 1);
    relay_flt = (kind == 2 || kind == 3);
    exp_d = (kind == 2) ? REL : (kind == 3) ? ((LOC < REL) ? LOC : REL) : LOC;
    @(posedge clk); #1;
    check_st((kind == 2) ? "R3 arm" : "R2 arm", 1);
    @(negedge clk);
    // late trigger of the other kind must be ignored (R4)
    oc_pos = 0; oc_neg = 0; relay_flt = 0;
    if (kind == 0 || kind == 1) relay_flt = 1;
    if (kind == 2) oc_neg = 1;
    if (exp_d > 1) begin
      tick_edges(exp_d - 1);
      check_st("R4 still pending", 1);
    end
    tick_edges(1);
    check_st((kind == 2) ? "R3 blocked" : (kind == 3) ? "R4 shorter wins" : "R2 blocked", 2);
    @(negedge clk);
    oc_pos = 0; oc_neg = 0; relay_flt = 0;
  endtask

  task automatic volt_release(input string req);
    @(negedge clk) volt_ok = 1;
    @(posedge clk); #1;
    check_st(req, 4);
    @(negedge clk) volt_ok = 0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: got 0 expected 1 (run completion)");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    tick = 0;
    do_reset();
    #1;
    check_st("R1 reset", 0);
    tick_edges(6);
    check_st("R1 idle holds", 0);

    // trigger paths, rectifier release by voltage
    for (int k = 0; k < 4; k++) begin
      do_reset();
      arm(k);
      tick_edges(2);
      check_st("R4 blocked ignores triggers", 2);
      volt_release("R7 voltage in blocked");
    end

    // isolation release, partial then full opening
    for (int m = 1; m < 4; m++) begin
      do_reset();
      disc_int = ND'(m);
      disc_open = (m == 3) ? 2'b01 : 2'b00;
      arm(0);
      tick_edges(MAXT + 2);
      check_st("R8 no timeout with internal", 2);
      @(negedge clk) disc_open = '1;
      @(posedge clk); #1;
      check_st("R6 isolation seen", 3);
      tick_edges(DEB - 1);
      check_st("R6 settling", 3);
      tick_edges(1);
      check_st("R6 released", 4);
    end

    // maximum blocked time, no internal disconnector
    do_reset();
    disc_open = '1;
    arm(2);
    tick_edges(MAXT - 1);
    check_st("R8 before limit", 2);
    tick_edges(1);
    check_st("R8 limit reached", 4);

    // inverter: only voltage releases
    for (int m = 0; m < 4; m++) begin
      do_reset();
      inv_mode = 1;
      disc_int = ND'(m);
      arm(1);
      @(negedge clk) disc_open = '1;
      tick_edges(MAXT + 3);
      check_st("R9 inverter held", 2);
      volt_release("R9 inverter voltage");
    end

    // voltage during de-block settling, then re-trigger from run
    do_reset();
    disc_int = 2'b10;
    arm(0);
    @(negedge clk) disc_open = 2'b10;
    @(posedge clk); #1;
    check_st("R6 isolation seen", 3);
    tick_edges(1);
    volt_release("R7 voltage in settling");
    @(negedge clk) oc_neg = 1;
    @(posedge clk); #1;
    check_st("R10 rearm from run", 1);
    @(negedge clk) oc_neg = 0;
    tick_edges(LOC);
    check_st("R10 blocked again", 2);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule